// File: doc/BRIEF.md
# Crossover-Searching Link Resolver

This controller brings up a twisted-pair port whose cable may be straight or crossed. When started, it drives the crossover select to the straight setting and waits one poll interval. It then asks a management access unit for the PHY basic status register and inspects the link bit. While no link is seen, the select toggles between straight and crossed before each new wait. A fixed number of polls is allowed. If all of them fail, the controller raises a fail flag.

Once a link is found, the controller re-reads the basic status register. If negotiation or parallel detection has completed, it reads a vendor status register to learn the speed and duplex. If auto-negotiation was used, it reads the expansion, advertisement and partner-ability registers in turn to decide whether pause is usable. The outcome is a four-bit port status word and a done flag. The delay reference is an external tick input, and the serial management signalling is handled by the access unit, outside this block.

Top module: `mdix_link_search`

## Requirements
- R1: A start pulse is accepted only when the controller is idle, including after done or fail. Acceptance sets xover_o to 0 (straight), clears done_o and fail_o, and clears status_o. A start pulse during a search has no effect on its outcome.
- R2: Each link poll is issued after exactly POLL_TICKS tick_i pulses have been counted in the wait phase. A link poll reads register 1, and bit 2 of the returned data means the link is up.
- R3: After a poll that finds no link and is not the last one, xover_o toggles before the next wait, with 0 meaning straight and 1 meaning crossed. The select is therefore 0 on even-numbered polls and 1 on odd-numbered polls (counting from 0), and it is not toggled after the final failing poll.
- R4: After MAX_POLLS polls without a link, fail_o is set, done_o stays 0 and status_o stays 0.
- R5: After a poll that finds the link up, register 1 is read again. If bit 5 of this re-read is clear, the controller finishes with only the link flag set.
- R6: If bit 5 of the re-read is set, register 31 is read and bits 4:2 are decoded: 1 means 10 Mb/s half duplex, 5 means 10 Mb/s full duplex, 2 means 100 Mb/s half duplex, and 6 means 100 Mb/s full duplex. Any other code leaves both the speed and duplex flags at 0.
- R7: If bit 3 of the re-read is set, register 6 is read next. Register 4 is read only if bit 0 of register 6 is set, and register 5 is read only if bit 10 of register 4 is set. The pause flag is set only if bit 10 of register 5 is set. The chain stops at the first clear bit.
- R8: rd_req_o stays high, with rd_reg_o unchanged, until the cycle in which rd_done_i is high. The data on rd_data_i is taken in that same cycle.
- R9: done_o or fail_o rises in the cycle right after the clock edge that takes the final read's rd_done_i. status_o is laid out as {pause, full duplex, 100 Mb/s, link}, from bit 3 down to bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a link search |
| tick_i | input | 1 | One-cycle delay reference pulse |
| rd_done_i | input | 1 | Register read complete; data valid this cycle |
| rd_data_i | input | DW | Register read data |
| xover_o | output | 1 | Crossover select: 0 straight, 1 crossed |
| rd_req_o | output | 1 | Register read request |
| rd_reg_o | output | RW | PHY register number for the request |
| status_o | output | 4 | {pause, full, 100M, link} |
| done_o | output | 1 | Search finished with link |
| fail_o | output | 1 | Poll limit reached without link |

## Verification
Each poll request should become visible in the cycle after the tick that completes POLL_TICKS. The bench counts tick pulses from the edge that entered the wait phase and expects exactly POLL_TICKS at the moment it first sees the request. The done or fail flag is due one cycle after the edge that takes the last rd_done_i. The bench records the cycle of each handshake in its PHY responder and compares it with the cycle in which the flag is first observed. Reads are answered after a latency of zero to two cycles, which exercises the hold-until-done rule. All sampling happens on the falling clock edge.

// File: rtl/mdix_pkg.sv
package mdix_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_POLL, S_RECHK, S_SPEED, S_ANEXP, S_ADV, S_LPA
  } st_t;

  typedef struct packed {
    logic pause;
    logic full;
    logic fast;
    logic link;
  } port_stat_t;

  localparam int unsigned REG_BSR   = 1;
  localparam int unsigned REG_ADV   = 4;
  localparam int unsigned REG_LPA   = 5;
  localparam int unsigned REG_ANEXP = 6;
  localparam int unsigned REG_VSTAT = 31;

  localparam int unsigned B_LINK  = 2;
  localparam int unsigned B_AN    = 3;
  localparam int unsigned B_ANC   = 5;
  localparam int unsigned B_LPAN  = 0;
  localparam int unsigned B_PAUSE = 10;
  localparam int unsigned B_SPD_LO = 2;
endpackage

// File: rtl/mdix_tick_timer.sv
module mdix_tick_timer #(
  parameter int unsigned TICKS = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || expire_o) cnt_q <= '0;
    else if (tick_i)            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdix_poll_counter.sv
module mdix_poll_counter #(
  parameter int unsigned MAX_POLLS = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic last_o
);
  localparam int unsigned CW = (MAX_POLLS > 1) ? $clog2(MAX_POLLS) : 1;
  localparam logic [CW-1:0] LAST = CW'(MAX_POLLS - 1);

  logic [CW-1:0] cnt_q;

  assign last_o = (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i && !last_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/mdix_speed_decode.sv
module mdix_speed_decode (
  input  logic [2:0] code_i,
  output logic       fast_o,
  output logic       full_o
);
  always_comb begin
    fast_o = 1'b0;
    full_o = 1'b0;
    unique case (code_i)
      3'd1: ;
      3'd5: full_o = 1'b1;
      3'd2: fast_o = 1'b1;
      3'd6: begin fast_o = 1'b1; full_o = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/mdix_link_search.sv
module mdix_link_search
  import mdix_pkg::*;
#(
  parameter int unsigned POLL_TICKS = 2000,
  parameter int unsigned MAX_POLLS  = 100,
  parameter int unsigned DW         = 16,
  parameter int unsigned RW         = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          tick_i,
  input  logic          rd_done_i,
  input  logic [DW-1:0] rd_data_i,
  output logic          xover_o,
  output logic          rd_req_o,
  output logic [RW-1:0] rd_reg_o,
  output logic [3:0]    status_o,
  output logic          done_o,
  output logic          fail_o
);
  st_t        state_q, state_d;
  port_stat_t stat_q;
  logic       xover_q, done_q, fail_q, an_q;
  logic       busy, accept, expire, last_poll;
  logic       finish, fail_set, flip, cap_an, cap_speed, cap_pause;
  logic       dec_fast, dec_full;

  assign busy   = (state_q != S_IDLE);
  assign accept = !busy && start_i;

  mdix_tick_timer #(.TICKS(POLL_TICKS)) u_timer (
    .clk_i, .rst_ni,
    .run_i   (state_q == S_WAIT),
    .tick_i,
    .expire_o(expire)
  );

  mdix_poll_counter #(.MAX_POLLS(MAX_POLLS)) u_polls (
    .clk_i, .rst_ni,
    .clr_i (accept),
    .inc_i (flip),
    .last_o(last_poll)
  );

  mdix_speed_decode u_dec (
    .code_i(rd_data_i[B_SPD_LO+:3]),
    .fast_o(dec_fast),
    .full_o(dec_full)
  );

  always_comb begin
    state_d   = state_q;
    finish    = 1'b0;
    fail_set  = 1'b0;
    flip      = 1'b0;
    cap_an    = 1'b0;
    cap_speed = 1'b0;
    cap_pause = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) state_d = S_WAIT;
      S_WAIT: if (expire)  state_d = S_POLL;
      S_POLL: if (rd_done_i) begin
        if (rd_data_i[B_LINK]) state_d = S_RECHK;
        else if (last_poll) begin fail_set = 1'b1; state_d = S_IDLE; end
        else begin flip = 1'b1; state_d = S_WAIT; end
      end
      S_RECHK: if (rd_done_i) begin
        cap_an = 1'b1;
        if (rd_data_i[B_ANC]) state_d = S_SPEED;
        else finish = 1'b1;
      end
      S_SPEED: if (rd_done_i) begin
        cap_speed = 1'b1;
        if (an_q) state_d = S_ANEXP;
        else finish = 1'b1;
      end
      S_ANEXP: if (rd_done_i) begin
        if (rd_data_i[B_LPAN]) state_d = S_ADV;
        else finish = 1'b1;
      end
      S_ADV: if (rd_done_i) begin
        if (rd_data_i[B_PAUSE]) state_d = S_LPA;
        else finish = 1'b1;
      end
      S_LPA: if (rd_done_i) begin
        cap_pause = 1'b1;
        finish    = 1'b1;
      end
      default: state_d = S_IDLE;
    endcase
    if (finish) state_d = S_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      stat_q  <= '0;
      xover_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
      an_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        stat_q  <= '0;
        xover_q <= 1'b0;
        done_q  <= 1'b0;
        fail_q  <= 1'b0;
        an_q    <= 1'b0;
      end
      if (flip)      xover_q <= ~xover_q;
      if (fail_set)  fail_q  <= 1'b1;
      if (cap_an)    an_q    <= rd_data_i[B_AN];
      if (cap_speed) begin
        stat_q.fast <= dec_fast;
        stat_q.full <= dec_full;
      end
      if (cap_pause) stat_q.pause <= rd_data_i[B_PAUSE];
      if (finish) begin
        stat_q.link <= 1'b1;
        done_q      <= 1'b1;
      end
    end
  end

  always_comb begin
    rd_req_o = 1'b1;
    unique case (state_q)
      S_POLL, S_RECHK: rd_reg_o = RW'(REG_BSR);
      S_SPEED:         rd_reg_o = RW'(REG_VSTAT);
      S_ANEXP:         rd_reg_o = RW'(REG_ANEXP);
      S_ADV:           rd_reg_o = RW'(REG_ADV);
      S_LPA:           rd_reg_o = RW'(REG_LPA);
      default: begin rd_reg_o = '0; rd_req_o = 1'b0; end
    endcase
  end

  assign xover_o  = xover_q;
  assign status_o = stat_q;
  assign done_o   = done_q;
  assign fail_o   = fail_q;
endmodule

// File: rtl/mdix_link_search_chk.sv
module mdix_link_search_chk #(
  parameter int unsigned RW = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy,
  input logic          rd_done_i,
  input logic          xover_o,
  input logic          rd_req_o,
  input logic [RW-1:0] rd_reg_o,
  input logic [3:0]    status_o,
  input logic          done_o,
  input logic          fail_o
);
  assert_start_clears_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy |=> !xover_o && !done_o && !fail_o && status_o == 4'd0);

  assert_xover_moves_on_event_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(xover_o) |-> $past(rd_done_i) || $past(start_i));

  assert_fail_clean_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !done_o && status_o == 4'd0);

  assert_req_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_o && !rd_done_i |=> rd_req_o && $stable(rd_reg_o));

  assert_done_has_link_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> status_o[0] && !busy);
endmodule

bind mdix_link_search mdix_link_search_chk #(.RW(RW)) u_chk (
  .clk_i, .rst_ni, .start_i, .busy, .rd_done_i, .xover_o,
  .rd_req_o, .rd_reg_o, .status_o, .done_o, .fail_o
);

// File: tb/tb_mdix_link_search.sv
module tb_mdix_link_search;
  localparam int PT = 3;
  localparam int MP = 5;

  logic        clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0, tick_i = 1'b0;
  logic        rd_done_i = 1'b0;
  logic [15:0] rd_data_i = '0;
  logic        xover_o, rd_req_o, done_o, fail_o;
  logic [4:0]  rd_reg_o;
  logic [3:0]  status_o;

  mdix_link_search #(.POLL_TICKS(PT), .MAX_POLLS(MP)) dut (.*);

  always #10 clk_i = ~clk_i;

  int cyc = 0, tb_ticks = 0;
  always @(posedge clk_i) begin
    cyc <= cyc + 1;
    if (tick_i) tb_ticks <= tb_ticks + 1;
  end

  int n_vec = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // scenario knobs
  int  need_x, min_reads, code, lat;
  bit  f_anc, f_an, f_6, f_4, f_5;
  int  reg_log[64];
  int  n_log, poll_idx, mark, hs_cyc;
  bit  prev_up;

  initial forever begin
    @(negedge clk_i);
    tick_i = (cyc % 2 == 0);
  end

  // PHY responder
  initial forever begin
    @(negedge clk_i);
    while (rd_req_o) begin
      automatic int r = int'(rd_reg_o);
      automatic logic [15:0] d = '0;
      automatic bit up;
      if (n_log < 64) reg_log[n_log] = r;
      n_log++;
      if (r == 1 && !prev_up) begin
        chk(tb_ticks - mark == PT, "R2 ticks before poll", tb_ticks - mark, PT);
        chk(int'(xover_o) == poll_idx % 2, "R3 select at poll", int'(xover_o), poll_idx % 2);
      end
      repeat (lat) @(negedge clk_i);
      case (r)
        1: begin
          up = prev_up || ((int'(xover_o) == need_x) && (poll_idx >= min_reads));
          d = 16'hFFD3 | (16'(up) << 2) | (16'(f_an) << 3) | (16'(f_anc) << 5);
          if (!prev_up) poll_idx++;
          prev_up = up;
        end
        31: d = 16'hFFE3 | (16'(code) << 2);
        6:  d = f_6 ? 16'h0001 : 16'hFFFE;
        4:  d = f_4 ? 16'h0400 : 16'hFBFF;
        5:  d = f_5 ? 16'h0400 : 16'hFBFF;
        default: d = 16'h0000;
      endcase
      rd_data_i = d;
      rd_done_i = 1'b1;
      @(negedge clk_i);
      rd_done_i = 1'b0;
      rd_data_i = '0;
      hs_cyc = cyc;
      mark = tb_ticks;
    end
  end

  task automatic run(input int nx, input int mr, input int cd, input bit anc, input bit an,
                     input bit b6, input bit b4, input bit b5, input bit mid, input int lt);
    int exp_log[64];
    int n_exp, p, t, end_cyc, exp_stat, exp_x;
    bit ok_seq;
    need_x = nx; min_reads = mr; code = cd; lat = lt;
    f_anc = anc; f_an = an; f_6 = b6; f_4 = b4; f_5 = b5;
    n_log = 0; poll_idx = 0; prev_up = 0;
    @(negedge clk_i); start_i = 1'b1;
    @(negedge clk_i); start_i = 1'b0; mark = tb_ticks;
    chk(!done_o && !fail_o && status_o == 0 && !xover_o, "R1 start clears", int'(status_o), 0);
    if (mid) begin
      repeat (2) @(negedge clk_i);
      start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
    end
    t = 0;
    while (!(done_o || fail_o) && t < 5000) begin @(negedge clk_i); t++; end
    end_cyc = cyc;
    #1;
    // expected outcome
    p = -1;
    for (int i = 0; i < MP; i++) if (p < 0 && (i % 2) == nx && i >= mr) p = i;
    n_exp = 0; exp_stat = 0;
    if (p < 0) begin
      for (int i = 0; i < MP; i++) exp_log[n_exp++] = 1;
      exp_x = (MP - 1) % 2;
      chk(fail_o && !done_o, "R4 fail raised", int'(fail_o), 1);
      chk(status_o == 0, "R4 status zero", int'(status_o), 0);
    end else begin
      for (int i = 0; i <= p + 1; i++) exp_log[n_exp++] = 1;
      exp_x = p % 2;
      exp_stat = 1;
      if (anc) begin
        exp_log[n_exp++] = 31;
        if (cd == 5 || cd == 6) exp_stat |= 4;
        if (cd == 2 || cd == 6) exp_stat |= 2;
        if (an) begin
          exp_log[n_exp++] = 6;
          if (b6) begin
            exp_log[n_exp++] = 4;
            if (b4) begin
              exp_log[n_exp++] = 5;
              if (b5) exp_stat |= 8;
            end
          end
        end
      end
      chk(done_o && !fail_o, "R5 done raised", int'(done_o), 1);
      chk(int'(status_o) == exp_stat, "R6/R7 status word", int'(status_o), exp_stat);
    end
    ok_seq = (n_log == n_exp);
    for (int i = 0; i < n_exp && i < 64; i++) if (ok_seq && reg_log[i] != exp_log[i]) ok_seq = 0;
    chk(ok_seq, "R7 read order", n_log, n_exp);
    chk(int'(xover_o) == exp_x, "R3 final select", int'(xover_o), exp_x);
    chk(end_cyc == hs_cyc, "R9 flag timing", end_cyc, hs_cyc);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !fail_o && !rd_req_o && !xover_o && status_o == 0,
        "R1 reset state", int'(status_o), 0);
    // polarity and poll-count sweep (R2 R3 R4 R8)
    for (int nx = 0; nx < 2; nx++)
      for (int mr = 0; mr <= MP + 1; mr++)
        run(nx, mr, 6, 1, 1, 1, 1, 1, 0, (nx + mr) % 3);
    // speed code sweep (R6)
    for (int c = 0; c < 8; c++) run(c % 2, 0, c, 1, 0, 1, 1, 1, 0, c % 3);
    // no completion bit (R5)
    run(0, 0, 6, 0, 1, 1, 1, 1, 0, 1);
    // pause chain sweep (R7)
    for (int m = 0; m < 16; m++)
      run(1, 2, 5, 1, m[3], m[2], m[1], m[0], 0, m % 3);
    // start while busy ignored (R1)
    run(1, 3, 2, 1, 1, 1, 1, 0, 1, 2);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule